// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This peripheral produces pulse-width-modulated waveforms on several independent output pins. Software sets each channel up through a small register bus with separate read and write strobes, a word address and 32-bit data. Every channel has three registers: a mode word, a period and a duty value.

The mode word holds three fields: the enable bit, the polarity bit and a 10-bit clock divider. A channel's prescaler turns the bus clock into a slower tick. A period counter steps once per tick and wraps after `period` ticks. The pin is active while the count is below the duty value.

The bus and the counters share one clock. When a channel is disabled, its counters are cleared and its pin rests at the inactive level that its polarity selects. Re-enabling the channel therefore always starts a fresh period.

Top module: `pwm_multi`

## Requirements
- R1: After reset every register reads zero, every channel is disabled, and every pin sits at logic 1. Polarity 0 is the inverted sense, so its inactive level is high.
- R2: `addr` is a word address, equal to the byte offset divided by 4. Channel n (0..3) occupies words (n+1)*4 to (n+1)*4+3. The mode word is at +0, the period at +1 and the duty at +2.
- R3: The mode word has the enable in bit 0, the polarity in bit 1 and the divider in bits 11:2. It reads back exactly as written, and bits 31:12 read zero. Read data appears in the cycle after `rdEn` and holds until the next read.
- R4: The period and duty registers are 16 bits wide. On readback, bits 31:16 are zero.
- R5: Addresses outside the channel map read zero, as does the fourth word of each channel block. Writes to these addresses change no register.
- R6: The prescaler produces one tick every `div` clocks. A divider of 0 behaves like a divider of 1.
- R7: A PWM cycle lasts `period` ticks, so rising edges of the pin are `period*div` clocks apart. A period of 0 behaves like a period of 1.
- R8: While enabled, the pin is active when the tick count is below `duty`. This gives `duty*div` active clocks in every `period*div` clocks.
- R9: If `duty` is greater than or equal to `period`, the pin is active all the time. If `duty` is 0, the pin is never active.
- R10: With polarity 1 the active level is high. With polarity 0 the active level is low.
- R11: A disabled channel holds its prescaler and counter at zero and drives its inactive level, which is the inverse of the polarity bit. After the enable is set, the first active stretch lasts exactly `duty*div` clocks.
- R12: The channels run independently. Configuring or running one channel does not disturb the pins of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the counters |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| pwmOut | output | NCH | One PWM pin per channel |

## Verification
The bench drives the duty value to exactly the period, above the period and to zero. A design that compared with the wrong sense would leave a one-tick notch in the full-duty case, or emit a stray pulse when the duty is zero. It sets a divider of zero and checks that the channel runs at full clock rate; a literal divide-by-zero would stall the counter or wrap it after 1024 clocks. It disables a running channel, then re-enables it and measures the first active stretch. A design that kept a stale count across the disable would start that stretch short. Readback goes to full-width writes and to the unused holes in the map, which exposes truncation faults and aliasing faults.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DIV_W  = 10;
  localparam int CNT_W  = 16;
  localparam int MODE_W = DIV_W + 2;

  typedef enum logic [1:0] {
    SLOT_MODE   = 2'd0,
    SLOT_PERIOD = 2'd1,
    SLOT_DUTY   = 2'd2,
    SLOT_NONE   = 2'd3
  } regSlot_e;

  // Register view of one channel
  typedef struct packed {
    logic             en;
    logic             pol;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
  } chanCfg_t;

  // What the counting datapath needs from control
  typedef struct packed {
    logic             run;
    logic             idleLevel;
    logic [DIV_W-1:0] divLast;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
  } chanCtl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output chanCfg_t          cfg [NCH],
  output chanCtl_t          ctl [NCH]
);
  localparam int BLK_W = ADDR_W - 2;

  logic [BLK_W-1:0]  blk;
  regSlot_e          slot;
  logic [DATA_W-1:0] rdPart [NCH];
  logic [DATA_W-1:0] rdNext;
  logic              unusedHiBits;

  assign blk          = addr[ADDR_W-1:2];
  assign slot         = regSlot_e'(addr[1:0]);
  assign unusedHiBits = ^wrData[DATA_W-1:CNT_W];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [MODE_W-1:0] modeQ;
    logic [CNT_W-1:0]  periodQ;
    logic [CNT_W-1:0]  dutyQ;
    logic              chSel;
    logic [DATA_W-1:0] slotVal;
    logic [DIV_W-1:0]  divQ;

    assign chSel = (blk == BLK_W'(i + 1));
    assign divQ  = modeQ[MODE_W-1:2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ   <= '0;
        periodQ <= '0;
        dutyQ   <= '0;
      end else if (wrEn && chSel) begin
        case (slot)
          SLOT_MODE:   modeQ   <= wrData[MODE_W-1:0];
          SLOT_PERIOD: periodQ <= wrData[CNT_W-1:0];
          SLOT_DUTY:   dutyQ   <= wrData[CNT_W-1:0];
          default:     ;
        endcase
      end
    end

    always_comb begin
      slotVal = '0;
      case (slot)
        SLOT_MODE:   slotVal[MODE_W-1:0] = modeQ;
        SLOT_PERIOD: slotVal[CNT_W-1:0]  = periodQ;
        SLOT_DUTY:   slotVal[CNT_W-1:0]  = dutyQ;
        default:     slotVal = '0;
      endcase
    end

    assign rdPart[i] = chSel ? slotVal : '0;

    assign cfg[i].en     = modeQ[0];
    assign cfg[i].pol    = modeQ[1];
    assign cfg[i].div    = divQ;
    assign cfg[i].period = periodQ;
    assign cfg[i].duty   = dutyQ;

    // Divider 0 and 1 both mean a tick on every clock
    assign ctl[i].run       = modeQ[0];
    assign ctl[i].idleLevel = ~modeQ[1];
    assign ctl[i].divLast   = (divQ == '0) ? '0 : divQ - DIV_W'(1);
    assign ctl[i].period    = periodQ;
    assign ctl[i].duty      = dutyQ;
  end

  always_comb begin
    rdNext = '0;
    for (int k = 0; k < NCH; k++) rdNext = rdNext | rdPart[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
  import pwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  chanCtl_t       ctl [NCH],
  output logic [NCH-1:0] pwmOut
);
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [DIV_W-1:0] presc;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] lastCount;
    logic             tick;
    logic             active;
    logic             outQ;

    // Period 0 and 1 both give a one-tick cycle
    assign lastCount = (ctl[i].period <= CNT_W'(1)) ? '0 : ctl[i].period - CNT_W'(1);
    // >= lets a shrunken divider or period take effect without a long wrap
    assign tick      = (presc >= ctl[i].divLast);
    assign active    = (ctl[i].duty != '0) &&
                       ((count < ctl[i].duty) || (ctl[i].duty >= ctl[i].period));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        presc <= '0;
        count <= '0;
        outQ  <= 1'b1;
      end else if (!ctl[i].run) begin
        presc <= '0;
        count <= '0;
        outQ  <= ctl[i].idleLevel;
      end else begin
        presc <= tick ? '0 : presc + DIV_W'(1);
        if (tick) count <= (count >= lastCount) ? '0 : count + CNT_W'(1);
        outQ  <= active ? ~ctl[i].idleLevel : ctl[i].idleLevel;
      end
    end

    assign pwmOut[i] = outQ;
  end
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = $clog2((NCH + 1) * 4),
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NCH-1:0]    pwmOut
);
  chanCfg_t chanCfg [NCH];
  chanCtl_t chanCtl [NCH];

  pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cfg(chanCfg), .ctl(chanCtl)
  );

  pwm_engine #(.NCH(NCH)) uEngine (
    .clk(clk), .rstN(rstN), .ctl(chanCtl), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic [NCH-1:0]    pwmOut,
  input chanCfg_t          cfg [NCH]
);
  logic [ADDR_W-3:0] blk;
  logic              holeAddr;

  assign blk      = addr[ADDR_W-1:2];
  assign holeAddr = (addr[1:0] == 2'd3) || (blk == '0) || (int'(blk) > NCH);

  // R5: unmapped words read as zero
  a_r5_hole_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && holeAddr |=> rdData == '0);

  // R3: read data holds between reads
  a_r3_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R3: mode readback matches the stored fields
    a_r3_mode_readback: assert property (@(posedge clk) disable iff (!rstN)
      rdEn && addr == ADDR_W'((i + 1) * 4) |=>
        rdData[MODE_W-1:0] == {$past(cfg[i].div), $past(cfg[i].pol), $past(cfg[i].en)}
        && rdData[DATA_W-1:MODE_W] == '0);

    // R11: disabled channel rests at inverse of polarity
    a_r11_idle_level: assert property (@(posedge clk) disable iff (!rstN)
      !cfg[i].en |=> pwmOut[i] == !$past(cfg[i].pol));

    // R9: zero duty never activates
    a_r9_zero_duty: assert property (@(posedge clk) disable iff (!rstN)
      cfg[i].en && cfg[i].duty == '0 |=> pwmOut[i] == !$past(cfg[i].pol));

    // R9: duty at or above period is always active
    a_r9_full_duty: assert property (@(posedge clk) disable iff (!rstN)
      cfg[i].en && cfg[i].duty != '0 && cfg[i].duty >= cfg[i].period
        |=> pwmOut[i] == $past(cfg[i].pol));
  end
endmodule

bind pwm_multi pwm_multi_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .rdData(rdData),
  .pwmOut(pwmOut), .cfg(chanCfg)
);

// File: tb/sim_pwm_multi.sv
module sim_pwm_multi;
  localparam int NCH    = 4;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [NCH-1:0]    pwmOut;

  pwm_multi #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] expQ [$];
  string             tagQ [$];
  logic              rdSeen = 1'b0;

  function automatic void check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  function automatic int regAddr(int ch, int slot);
    return (ch + 1) * 4 + slot;
  endfunction

  // Monitor: pops expected readback when the design presents it
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [DATA_W-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(rdData == e, t, "readback", longint'(rdData), longint'(e));
    end
  end

  task automatic wr(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Driver: pushes the expected item, then issues the read
  task automatic rd(int a, logic [DATA_W-1:0] e, string tag);
    @(negedge clk);
    expQ.push_back(e); tagQ.push_back(tag);
    rdEn = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countHigh(int ch, int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwmOut[ch]) c++;
    end
  endtask

  task automatic riseGap(int ch, output int g);
    logic prev;
    g = 0;
    @(negedge clk); prev = pwmOut[ch];
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (pwmOut[ch] && !prev) break;
      prev = pwmOut[ch];
    end
    prev = pwmOut[ch];
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      g++;
      if (pwmOut[ch] && !prev) break;
      prev = pwmOut[ch];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    int g;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1: reset state
    check(pwmOut == 4'hF, "R1", "pins after reset", longint'(pwmOut), 15);
    for (int ch = 0; ch < NCH; ch++) rd(regAddr(ch, 0), 32'h0, "R1");
    rd(regAddr(3, 1), 32'h0, "R1");

    // R3: mode field widths and readback
    wr(regAddr(2, 0), 32'hFFFF_FFFF);
    rd(regAddr(2, 0), 32'h0000_0FFF, "R3");
    wr(regAddr(2, 0), 32'h0000_0FFE);
    rd(regAddr(2, 0), 32'h0000_0FFE, "R3");
    wr(regAddr(2, 0), 32'h0);

    // R4: 16-bit period and duty
    wr(regAddr(3, 1), 32'hABCD_1234);
    rd(regAddr(3, 1), 32'h0000_1234, "R4");
    wr(regAddr(3, 2), 32'h0001_5678);
    rd(regAddr(3, 2), 32'h0000_5678, "R4");

    // R2: each channel's window is distinct
    for (int ch = 0; ch < NCH; ch++) wr(regAddr(ch, 1), 32'h100 + ch);
    for (int ch = 0; ch < NCH; ch++) rd(regAddr(ch, 1), 32'h100 + ch, "R2");

    // R5: holes read zero and ignore writes
    wr(regAddr(0, 3), 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    rd(regAddr(0, 3), 32'h0, "R5");
    rd(0, 32'h0, "R5");
    rd(20, 32'h0, "R5");
    rd(31, 32'h0, "R5");
    rd(regAddr(0, 0), 32'h0, "R5");
    rd(regAddr(0, 1), 32'h100, "R5");
    rd(regAddr(0, 2), 32'h0, "R5");

    // Configure channels
    wr(regAddr(0, 1), 10); wr(regAddr(0, 2), 3); wr(regAddr(0, 0), 32'h7);
    wr(regAddr(1, 1), 5);  wr(regAddr(1, 2), 2); wr(regAddr(1, 0), 32'hF);
    wr(regAddr(3, 1), 8);  wr(regAddr(3, 2), 2); wr(regAddr(3, 0), 32'h1);
    idle(50);

    countHigh(0, 10, c); check(c == 3, "R8", "ch0 active clocks", c, 3);
    countHigh(1, 15, c); check(c == 6, "R6", "ch1 div3 active clocks", c, 6);
    riseGap(1, g);       check(g == 15, "R7", "ch1 edge spacing", g, 15);
    countHigh(3, 8, c);  check(c == 6, "R10", "ch3 inverted high clocks", c, 6);
    countHigh(2, 30, c); check(c == 30, "R12", "ch2 idle undisturbed", c, 30);

    // R6: divider zero acts as one
    wr(regAddr(1, 0), 32'h3);
    idle(20);
    countHigh(1, 5, c); check(c == 2, "R6", "ch1 div0 active clocks", c, 2);
    riseGap(1, g);      check(g == 5, "R6", "ch1 div0 edge spacing", g, 5);

    // R9: full and zero duty
    wr(regAddr(0, 2), 12); idle(20);
    countHigh(0, 10, c); check(c == 10, "R9", "duty above period", c, 10);
    wr(regAddr(0, 2), 10); idle(20);
    countHigh(0, 10, c); check(c == 10, "R9", "duty equal period", c, 10);
    wr(regAddr(0, 2), 0);  idle(20);
    countHigh(0, 10, c); check(c == 0, "R9", "duty zero", c, 0);

    // R7: period change
    wr(regAddr(0, 1), 4); wr(regAddr(0, 2), 1); idle(20);
    countHigh(0, 4, c); check(c == 1, "R7", "period4 active clocks", c, 1);
    riseGap(0, g);      check(g == 4, "R7", "period4 edge spacing", g, 4);

    // R11: disable holds idle level, re-enable starts fresh
    wr(regAddr(0, 0), 32'h6); idle(3);
    countHigh(0, 20, c); check(c == 0, "R11", "disabled pol1 level", c, 0);
    wr(regAddr(0, 1), 10); wr(regAddr(0, 2), 4); wr(regAddr(0, 0), 32'hA);
    idle(5);
    wr(regAddr(0, 0), 32'hB);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (pwmOut[0]) break;
    end
    c = 1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!pwmOut[0]) break;
      c++;
    end
    check(c == 8, "R11", "first active stretch", c, 8);
    idle(30);
    countHigh(0, 20, c); check(c == 8, "R8", "div2 active clocks", c, 8);

    wr(regAddr(3, 0), 32'h0); idle(3);
    countHigh(3, 20, c); check(c == 20, "R11", "disabled pol0 level", c, 20);

    idle(5);
    check(expQ.size() == 0, "R3", "reads pending", expQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule